// File: doc/BRIEF.md
# Calendar Real-Time Clock with Write-Locked Counters

This block keeps wall-clock time and a calendar date in binary fields: seconds, minutes, hours, day of month, month, a two-digit year and a separate century. An external one-cycle pulse, normally derived from a 1 Hz reference, moves the time forward by one second whenever counting is switched on. Carries ripple through the whole calendar, including month lengths, leap years and century wrap.

Software sees the clock through a small 32-bit register window. Two counter words show the running time and date. A control word turns counting on and off, and it opens or closes a write lock on the counter words, so that a stray store cannot corrupt the clock. Slots reserved for an alarm are present in the map but read as zero and do nothing. Read data is registered and appears one cycle after the read strobe.

Top module: `cal_rtc_top`

## Requirements
- R1: After reset every counter field and every control bit is zero, so reads of the time word, the date word and the control word all return 0.
- R2: The word index is taken from address bits [4:2]: byte offset 0x00 holds the time word, 0x04 the date word and 0x10 the control word. Control bit 0 enables counting and bit 1 unlocks the counters. Control bits 31:2 always read as zero.
- R3: The time word packs seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and day of month in bits 28:24. All other bits read as zero.
- R4: The date word packs the month (1 to 12) in bits 3:0, the year within the century in bits 14:8 and the century in bits 20:16. All other bits read as zero.
- R5: A tick pulse while control bit 0 is set advances the seconds by one. While control bit 0 is clear, ticks are ignored and both counter words keep their values.
- R6: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R7: After the last day of its month the day returns to 1 and the month advances. April, June, September and November have 30 days, February has 28 or 29, and the rest have 31.
- R8: February has 29 days when the full year (century times 100 plus year) is divisible by 400, or is divisible by 4 but not by 100.
- R9: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0 and carries into the century. The century wraps from 31 to 0.
- R10: A write to the time or date word takes effect only while control bit 1 is set. Otherwise it is dropped without trace. The control word can be written at any time.
- R11: A permitted counter write lands at the clock edge that ends its cycle. A tick in that same cycle is discarded, so the written value is what reads back.
- R12: The alarm slots at 0x08 and 0x14, and every unmapped word index, read as zero and ignore writes.
- R13: Read data appears on the clock edge after the cycle in which the read strobe is high, and it reflects the state before that edge. In a cycle without a read strobe, the read data is zero one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| addr_i | input | 5 | Byte address within the register window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that any value written to a counter word is a valid calendar value. Seconds and minutes must be 59 or less, hours 23 or less, the month 1 to 12, the year 99 or less, and the day no larger than its month allows. The stimulus writes only such values. It reaches the rollover corners by loading a time one second before the boundary and then issuing a single tick. The leap-year rule is covered in the 2000, 2024 and 2100 cases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [2:0] IDX_TIME  = 3'd0;
  localparam logic [2:0] IDX_DATE  = 3'd1;
  localparam logic [2:0] IDX_ALRM  = 3'd2;
  localparam logic [2:0] IDX_CTRL  = 3'd4;
  localparam logic [2:0] IDX_ASTAT = 3'd5;

  localparam logic [DATA_W-1:0] TIME_MASK = 32'h1F1F_3F3F;
  localparam logic [DATA_W-1:0] DATE_MASK = 32'h001F_7F0F;

  typedef struct packed {
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  typedef struct packed {
    logic [4:0] cent;
    logic [6:0] year;
    logic [3:0] mon;
  } rtc_date_t;

  typedef struct packed {
    logic unlock;
    logic run_en;
  } rtc_ctrl_t;

  function automatic logic [DATA_W-1:0] pack_time(rtc_time_t t);
    return {3'b0, t.day, 3'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic logic [DATA_W-1:0] pack_date(rtc_date_t d);
    return {11'b0, d.cent, 1'b0, d.year, 4'b0, d.mon};
  endfunction

  function automatic rtc_time_t unpack_time(logic [DATA_W-1:0] w);
    rtc_time_t t;
    t.day  = w[28:24];
    t.hour = w[20:16];
    t.min  = w[13:8];
    t.sec  = w[5:0];
    return t;
  endfunction

  function automatic rtc_date_t unpack_date(logic [DATA_W-1:0] w);
    rtc_date_t d;
    d.cent = w[20:16];
    d.year = w[14:8];
    d.mon  = w[3:0];
    return d;
  endfunction
endpackage

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] max_i,
  input  logic [W-1:0] min_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top  = (cnt_q >= max_i);
  assign carry_o = inc_i & at_top;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= at_top ? min_i : cnt_q + W'(1);
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [3:0] mon_i,
  input  logic [6:0] year_i,
  input  logic [4:0] cent_i,
  output logic [4:0] last_day_o
);
  logic leap;

  // Year 00 defers to century: full year divisible by 400 iff century divisible by 4.
  always_comb begin
    if (year_i == 7'd0) leap = (cent_i[1:0] == 2'b00);
    else                leap = (year_i[1:0] == 2'b00);
  end

  always_comb begin
    unique case (mon_i)
      4'd2:                      last_day_o = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   last_day_o = 5'd30;
      default:                   last_day_o = 5'd31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              ld_time_i,
  input  logic              ld_date_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rtc_time_t         time_o,
  output rtc_date_t         date_o
);
  localparam int unsigned NF = 7;
  localparam int unsigned MW = 7;

  rtc_time_t ld_t;
  rtc_date_t ld_d;
  logic [4:0] last_day;

  logic [MW-1:0] cnt   [NF];
  logic [MW-1:0] ldv   [NF];
  logic [MW-1:0] maxv  [NF];
  logic [MW-1:0] minv  [NF];
  logic [NF-1:0] ld;
  logic [NF:0]   carry;

  localparam int unsigned FW [NF] = '{6, 6, 5, 5, 4, 7, 5};

  assign ld_t = unpack_time(wdata_i);
  assign ld_d = unpack_date(wdata_i);

  // field order: sec, min, hour, day, month, year, century
  always_comb begin
    ldv[0] = MW'(ld_t.sec);   maxv[0] = MW'(59);       minv[0] = '0;
    ldv[1] = MW'(ld_t.min);   maxv[1] = MW'(59);       minv[1] = '0;
    ldv[2] = MW'(ld_t.hour);  maxv[2] = MW'(23);       minv[2] = '0;
    ldv[3] = MW'(ld_t.day);   maxv[3] = MW'(last_day); minv[3] = MW'(1);
    ldv[4] = MW'(ld_d.mon);   maxv[4] = MW'(12);       minv[4] = MW'(1);
    ldv[5] = MW'(ld_d.year);  maxv[5] = MW'(99);       minv[5] = '0;
    ldv[6] = MW'(ld_d.cent);  maxv[6] = MW'(31);       minv[6] = '0;
    ld = {{3{ld_date_i}}, {4{ld_time_i}}};
  end

  assign carry[0] = step_i;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [FW[g]-1:0] c;
    rtc_wrap_cnt #(.W(FW[g])) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (carry[g]),
      .load_i     (ld[g]),
      .load_val_i (ldv[g][FW[g]-1:0]),
      .max_i      (maxv[g][FW[g]-1:0]),
      .min_i      (minv[g][FW[g]-1:0]),
      .cnt_o      (c),
      .carry_o    (carry[g+1])
    );
    assign cnt[g] = MW'(c);
  end

  rtc_month_len u_mlen (
    .mon_i      (cnt[4][3:0]),
    .year_i     (cnt[5][6:0]),
    .cent_i     (cnt[6][4:0]),
    .last_day_o (last_day)
  );

  assign time_o = '{day: cnt[3][4:0], hour: cnt[2][4:0], min: cnt[1][5:0], sec: cnt[0][5:0]};
  assign date_o = '{cent: cnt[6][4:0], year: cnt[5][6:0], mon: cnt[4][3:0]};
endmodule

// File: rtl/cal_rtc_top.sv
module cal_rtc_top
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  rtc_ctrl_t         ctrl_q;
  logic              wr_time, wr_date, step;
  rtc_time_t         cur_t;
  rtc_date_t         cur_d;
  logic [DATA_W-1:0] time_w, date_w, rd_mux, rdata_q;

  assign idx     = addr_i[ADDR_W-1:2];
  assign wr_time = we_i & ctrl_q.unlock & (idx == IW'(IDX_TIME));
  assign wr_date = we_i & ctrl_q.unlock & (idx == IW'(IDX_DATE));
  // a tick colliding with a counter load is dropped
  assign step    = tick_i & ctrl_q.run_en & ~(wr_time | wr_date);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && idx == IW'(IDX_CTRL)) ctrl_q <= rtc_ctrl_t'(wdata_i[1:0]);
  end

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .ld_time_i (wr_time),
    .ld_date_i (wr_date),
    .wdata_i   (wdata_i),
    .time_o    (cur_t),
    .date_o    (cur_d)
  );

  assign time_w = pack_time(cur_t);
  assign date_w = pack_date(cur_d);

  always_comb begin
    rd_mux = '0;
    if (idx == IW'(IDX_TIME))      rd_mux = time_w;
    else if (idx == IW'(IDX_DATE)) rd_mux = date_w;
    else if (idx == IW'(IDX_CTRL)) rd_mux = {30'b0, ctrl_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       time_w,
  input logic [31:0]       date_w,
  input logic [1:0]        ctrl_q
);
  logic [ADDR_W-3:0] wi;
  logic cnt_slot, dead_slot;
  assign wi        = addr_i[ADDR_W-1:2];
  assign cnt_slot  = (wi == 0) || (wi == 1);
  assign dead_slot = (wi == 2) || (wi == 3) || (wi >= 5);

  AST_LOCKED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && cnt_slot && !ctrl_q[1] && !ctrl_q[0] |=> $stable(time_w) && $stable(date_w)); // R10
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[0] && !(we_i && cnt_slot && ctrl_q[1]) |=> $stable(time_w) && $stable(date_w)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && ctrl_q[1] && wi == 0 |=> time_w == ($past(wdata_i) & 32'h1F1F_3F3F)); // R11
  AST_DEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && dead_slot |=> rdata_o == 32'h0); // R12
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && ctrl_q[0] && !we_i && time_w[5:0] == 6'd59 |=> time_w[5:0] == 6'd0); // R6
  AST_CTRL_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && wi == 4 |=> rdata_o[31:2] == 30'h0); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == 32'h0); // R13
endmodule

bind cal_rtc_top cal_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .time_w  (time_w),
  .date_w  (date_w),
  .ctrl_q  (ctrl_q)
);

// File: tb/cal_rtc_top_tb_top.sv
module cal_rtc_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_cent, m_en, m_unl;

  always #5 clk_i = ~clk_i;

  cal_rtc_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_o)
  );

  function automatic logic [31:0] tw(int d, int h, int m, int s);
    return (32'(d) << 24) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] dw(int c, int y, int mo);
    return (32'(c) << 16) | (32'(y) << 8) | 32'(mo);
  endfunction

  function automatic bit is_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return is_leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a >> 2)
      0: return tw(m_day, m_hr, m_min, m_sec);
      1: return dw(m_cent, m_yr, m_mon);
      4: return 32'(m_unl * 2 + m_en);
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_advance();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_day++;
          if (m_day > dim(m_mon, m_cent * 100 + m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon > 12) begin
              m_mon = 1; m_yr++;
              if (m_yr == 100) begin
                m_yr = 0; m_cent = (m_cent + 1) % 32;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic m_update(logic [4:0] a, logic w, logic [31:0] d, logic t);
    int old_en = m_en;
    bit cnt_wr = 0;
    if (w) begin
      if ((a >> 2) == 0 && m_unl == 1) begin
        m_day = int'(d[28:24]); m_hr = int'(d[20:16]);
        m_min = int'(d[13:8]);  m_sec = int'(d[5:0]); cnt_wr = 1;
      end else if ((a >> 2) == 1 && m_unl == 1) begin
        m_cent = int'(d[20:16]); m_yr = int'(d[14:8]); m_mon = int'(d[3:0]); cnt_wr = 1;
      end else if ((a >> 2) == 4) begin
        m_en = int'(d[0]); m_unl = int'(d[1]);
      end
    end
    if (t && old_en == 1 && !cnt_wr) m_advance();
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, advance model, compare registered read data
  task automatic step(logic [4:0] a, logic w, logic [31:0] d, logic r, logic t, string tag);
    logic [31:0] exp;
    @(negedge clk_i);
    addr_i = a; we_i = w; wdata_i = d; re_i = r; tick_i = t;
    exp = r ? m_read(a) : 32'h0;
    m_update(a, w, d, t);
    @(posedge clk_i);
    #1;
    check(tag, rdata_o, exp);
  endtask

  task automatic rd(logic [4:0] a, string tag);
    step(a, 1'b0, 32'h0, 1'b1, 1'b0, tag);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
    step(a, 1'b1, d, 1'b0, 1'b0, tag);
  endtask

  task automatic tick(string tag);
    step(5'h0, 1'b0, 32'h0, 1'b0, 1'b1, tag);
  endtask

  task automatic set_clock(int c, int y, int mo, int d, int h, int mi, int s, string tag);
    wr(5'h10, 32'h2, tag);
    wr(5'h00, tw(d, h, mi, s), tag);
    wr(5'h04, dw(c, y, mo), tag);
    wr(5'h10, 32'h1, tag);
  endtask

  task automatic rd_all(string tag);
    rd(5'h00, tag);
    rd(5'h04, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_mon = 0; m_yr = 0; m_cent = 0; m_en = 0; m_unl = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h10, "R1");
    // R5 ticks ignored while disabled
    tick("R5"); rd_all("R5");
    // R2 control width and offsets
    wr(5'h10, 32'hFFFF_FFFC, "R2"); rd(5'h10, "R2");
    wr(5'h10, 32'hFFFF_FFFF, "R2"); rd(5'h10, "R2");
    // R3 R4 field packing
    set_clock(20, 19, 7, 14, 9, 33, 12, "R3"); rd_all("R4");
    // R5 enabled ticks advance
    tick("R5"); tick("R5"); rd(5'h00, "R5");
    // R6 R7 R9 new year rollover
    set_clock(20, 23, 12, 31, 23, 59, 58, "R6");
    tick("R6"); rd(5'h00, "R6"); tick("R9"); rd_all("R9");
    // R7 30-day month
    set_clock(20, 24, 4, 30, 23, 59, 59, "R7"); tick("R7"); rd_all("R7");
    set_clock(20, 24, 1, 30, 23, 59, 59, "R7"); tick("R7"); rd_all("R7");
    // R8 leap rules
    set_clock(20, 24, 2, 28, 23, 59, 59, "R8"); tick("R8"); rd_all("R8");
    tick("R8"); rd_all("R8");
    set_clock(20, 24, 2, 29, 23, 59, 59, "R8"); tick("R8"); rd_all("R8");
    set_clock(21, 0, 2, 28, 23, 59, 59, "R8"); tick("R8"); rd_all("R8");
    set_clock(20, 0, 2, 28, 23, 59, 59, "R8"); tick("R8"); rd_all("R8");
    set_clock(20, 23, 2, 28, 23, 59, 59, "R8"); tick("R8"); rd_all("R8");
    // R9 century carry and wrap
    set_clock(19, 99, 12, 31, 23, 59, 59, "R9"); tick("R9"); rd_all("R9");
    set_clock(31, 99, 12, 31, 23, 59, 59, "R9"); tick("R9"); rd_all("R9");
    // R10 locked writes dropped, enabled and disabled
    wr(5'h00, tw(5, 5, 5, 5), "R10"); wr(5'h04, dw(3, 3, 3), "R10"); rd_all("R10");
    wr(5'h10, 32'h0, "R10");
    wr(5'h00, tw(6, 6, 6, 6), "R10"); rd_all("R10");
    // R11 write wins over same-cycle tick
    wr(5'h10, 32'h3, "R11");
    step(5'h00, 1'b1, tw(2, 3, 4, 5), 1'b0, 1'b1, "R11"); rd(5'h00, "R11");
    step(5'h04, 1'b1, dw(20, 25, 6), 1'b0, 1'b1, "R11"); rd_all("R11");
    // R12 alarm and unmapped slots
    wr(5'h08, 32'hFFFF_FFFF, "R12"); rd(5'h08, "R12");
    wr(5'h14, 32'hFFFF_FFFF, "R12"); rd(5'h14, "R12");
    wr(5'h0C, 32'h1234_5678, "R12"); rd(5'h0C, "R12");
    wr(5'h1C, 32'h0000_0000, "R12"); rd(5'h1C, "R12");
    rd(5'h10, "R12"); rd_all("R12");
    // R13 latency and idle zero
    rd(5'h00, "R13");
    step(5'h00, 1'b0, 32'h0, 1'b0, 1'b1, "R13");
    rd(5'h00, "R13");
    step(5'h00, 1'b0, 32'h0, 1'b1, 1'b1, "R13");
    rd(5'h00, "R13");
    step(5'h10, 1'b0, 32'h0, 1'b0, 1'b0, "R13");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule